// File: doc/BRIEF.md
# Triggered One-Pulse Timer Channel

This block produces a single timed pulse each time a chosen edge shows up on an asynchronous trigger line. The trigger is first resynchronised and then edge-detected. An accepted edge starts an up-counter that runs from 0 to a reload limit and then stops by itself. While the counter runs, the pulse output follows a compare against a programmable threshold. One channel mode makes the output active before the threshold is reached. The other makes it active after the threshold. A third setting keeps the output held low.

A fast-start option takes out the compare stage at the start of a pulse. In either PWM mode, the output jumps to the level a threshold match would give on the same clock edge that starts the counter. It holds that level until the run ends. This gives the shortest delay from trigger to output, at the cost of the programmed compare delay. A busy flag shows whether a run is in progress. New trigger edges are disregarded while busy is high.

Top module: `opm_pulse_gen`

## Requirements
- R1: With `edge_falling` = 0 a low-to-high transition of `trig_in` is the start edge, with `edge_falling` = 1 a high-to-low transition is; when `busy` is low, `busy` rises on the third rising clock edge after the transition (two synchroniser stages plus edge detection) and the counter starts at 0.
- R2: A run lasts `reload_val`+1 clock cycles: the counter steps 0,1,...,`reload_val`, and on the edge after it holds `reload_val` it returns to 0 and `busy` falls.
- R3: With `mode_sel` = 2'b01 (PWM mode 1) and `fast_start` = 0, `pulse_out` is high in the cycle after each counter value c with c < `cmp_val` and c < `reload_val`, and low otherwise.
- R4: With `mode_sel` = 2'b10 (PWM mode 2) and `fast_start` = 0, `pulse_out` is high in the cycle after each counter value c with `cmp_val` <= c < `reload_val`, and low otherwise.
- R5: With `mode_sel` = 2'b10 and `fast_start` = 1, `pulse_out` goes high on the same clock edge on which `busy` rises and falls on the same edge on which `busy` falls.
- R6: With `mode_sel` = 2'b01 and `fast_start` = 1, `pulse_out` is held at the PWM mode 1 post-match level, which is low, for the whole run.
- R7: With `mode_sel` = 2'b00 or 2'b11 (frozen), `pulse_out` stays low whatever `fast_start` is, while `busy` still runs for `reload_val`+1 cycles.
- R8: Start edges that arrive while `busy` is high are ignored: the run neither restarts nor gets longer, and no second run follows it.
- R9: While `rst` is high, `pulse_out` and `busy` are low after the next clock edge.
- R10: Whenever `busy` is low, `pulse_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous trigger line |
| edge_falling | input | 1 | Start edge select: 0 rising, 1 falling |
| mode_sel | input | 2 | Channel mode: 01 PWM mode 1, 10 PWM mode 2, 00/11 frozen |
| fast_start | input | 1 | Force the post-match level at the start edge (PWM modes only) |
| cmp_val | input | CNT_W | Compare threshold |
| reload_val | input | CNT_W | Last counter value of a run |
| pulse_out | output | 1 | Pulse output |
| busy | output | 1 | High while a run is in progress |

## Verification
The assertions check on every cycle that the output is low whenever the channel is idle. They also check that a run always starts at zero, steps by one and ends right after the reload value, and that no restart happens during a run. They check the fast-start level in both PWM modes and the held-low output in the frozen modes. Only the bench scenarios show the exact trigger-to-busy latency through the synchroniser, and the cycle-by-cycle pulse shape for each mix of threshold, reload value, mode and edge polarity. They also cover the absence of any run after a trigger edge that was dropped during a busy period.

// File: rtl/opm_pkg.sv
package opm_pkg;

    typedef enum logic [1:0] {
        CH_FROZEN     = 2'b00,
        CH_PWM_LOW    = 2'b01,
        CH_PWM_HIGH   = 2'b10,
        CH_FROZEN_ALT = 2'b11
    } ch_mode_e;

    // Only the two PWM modes drive a compare-dependent level.
    function automatic logic mode_is_pwm(ch_mode_e m);
        return (m == CH_PWM_LOW) || (m == CH_PWM_HIGH);
    endfunction

    // Level a threshold match leaves the reference at.
    function automatic logic post_match_level(ch_mode_e m);
        return (m == CH_PWM_HIGH);
    endfunction

    // Reference level for a counter value either below or at/above threshold.
    function automatic logic ref_level(ch_mode_e m, logic below_cmp);
        case (m)
            CH_PWM_LOW:  return below_cmp;
            CH_PWM_HIGH: return !below_cmp;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/opm_trig_sync.sv
module opm_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic edge_falling,
    output logic edge_hit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= trig_in;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= 1'b0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    always_comb begin
        if (edge_falling) edge_hit = !chain_q[LAST] && prev_q;
        else              edge_hit = chain_q[LAST] && !prev_q;
    end

endmodule

// File: rtl/opm_counter.sv
module opm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] reload_val,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    assign at_end = run && (cnt == reload_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (at_end) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/opm_out_stage.sv
module opm_out_stage
    import opm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             at_end,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  ch_mode_e         mode,
    input  logic             fast_start,
    output logic             pulse
);
    logic fast_active;
    logic pulse_d;

    assign fast_active = fast_start && mode_is_pwm(mode);

    always_comb begin
        if (start && fast_active) begin
            pulse_d = post_match_level(mode);
        end else if (run && !at_end) begin
            if (fast_active) pulse_d = post_match_level(mode);
            else             pulse_d = ref_level(mode, cnt < cmp_val);
        end else begin
            pulse_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= pulse_d;
    end

endmodule

// File: rtl/opm_pulse_gen.sv
module opm_pulse_gen
    import opm_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_in,
    input  logic             edge_falling,
    input  logic [1:0]       mode_sel,
    input  logic             fast_start,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             pulse_out,
    output logic             busy
);
    logic             edge_hit;
    logic             start;
    logic             run_q;
    logic             at_end;
    logic [CNT_W-1:0] cnt_q;
    ch_mode_e         mode;

    assign mode  = ch_mode_e'(mode_sel);
    assign start = edge_hit && !run_q;
    assign busy  = run_q;

    opm_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk          (clk),
        .rst          (rst),
        .trig_in      (trig_in),
        .edge_falling (edge_falling),
        .edge_hit     (edge_hit)
    );

    opm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .reload_val (reload_val),
        .run        (run_q),
        .cnt        (cnt_q),
        .at_end     (at_end)
    );

    opm_out_stage #(.CNT_W(CNT_W)) out_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .run        (run_q),
        .at_end     (at_end),
        .cnt        (cnt_q),
        .cmp_val    (cmp_val),
        .mode       (mode),
        .fast_start (fast_start),
        .pulse      (pulse_out)
    );

endmodule

// File: rtl/opm_pulse_gen_chk.sv
module opm_pulse_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_sel,
    input logic             fast_start,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] cnt,
    input logic             busy,
    input logic             pulse_out
);
    logic frozen;
    logic fast_low;
    assign frozen   = (mode_sel == 2'b00) || (mode_sel == 2'b11);
    assign fast_low = fast_start && (mode_sel == 2'b01);

    AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt == '0)); // R1

    AST_RUN_ENDS_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == reload_val && $stable(reload_val)) |=> !busy); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != reload_val) |=> (busy && cnt == CNT_W'($past(cnt) + 1'b1))); // R8

    AST_FAST_LEADS: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && fast_start && mode_sel == 2'b10 && $stable(mode_sel)) |-> pulse_out); // R5

    AST_FAST_PWM1_LOW: assert property (@(posedge clk) disable iff (rst)
        (fast_low && $past(fast_low)) |-> !pulse_out); // R6

    AST_FROZEN_LOW: assert property (@(posedge clk) disable iff (rst)
        (frozen && $past(frozen)) |-> !pulse_out); // R7

    AST_IDLE_OUTPUT_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !pulse_out); // R10

endmodule

bind opm_pulse_gen opm_pulse_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .fast_start (fast_start),
    .reload_val (reload_val),
    .cnt        (cnt_q),
    .busy       (busy),
    .pulse_out  (pulse_out)
);

// File: tb/opm_pulse_gen_tb.sv
module opm_pulse_gen_tb_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_in = 1'b0;
    logic             edge_falling = 1'b0;
    logic [1:0]       mode_sel = 2'b01;
    logic             fast_start = 1'b0;
    logic [CNT_W-1:0] cmp_val = '0;
    logic [CNT_W-1:0] reload_val = '0;
    logic             pulse_out;
    logic             busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    opm_pulse_gen #(.CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .trig_in      (trig_in),
        .edge_falling (edge_falling),
        .mode_sel     (mode_sel),
        .fast_start   (fast_start),
        .cmp_val      (cmp_val),
        .reload_val   (reload_val),
        .pulse_out    (pulse_out),
        .busy         (busy)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // Expected output j cycles after the start edge (j = 0 is the start edge).
    function automatic logic exp_pulse(int mode, int fast, int cmp, int arr, int j);
        bit pwm = (mode == 1) || (mode == 2);
        int c;
        if (j < 0 || j > arr) return 1'b0;
        if (fast != 0 && pwm) return (mode == 2);
        if (j < 1) return 1'b0;
        c = j - 1;
        if (mode == 1) return (c < cmp);
        if (mode == 2) return (c >= cmp);
        return 1'b0;
    endfunction

    function automatic string pulse_tag(int mode, int fast, int j, int arr);
        if (j < 0 || j > arr) return "R10";
        if (mode != 1 && mode != 2) return "R7";
        if (fast != 0) return (mode == 2) ? "R5" : "R6";
        return (mode == 1) ? "R3" : "R4";
    endfunction

    // One trigger with a full window of checks; retrig drops a second edge mid-run.
    task automatic run_pulse(input int pol, input int mode, input int fast,
                             input int cmp, input int arr, input bit retrig);
        @(negedge clk);
        edge_falling = pol[0];
        mode_sel     = mode[1:0];
        fast_start   = fast[0];
        cmp_val      = CNT_W'(cmp);
        reload_val   = CNT_W'(arr);
        trig_in      = pol[0];
        repeat (4) @(negedge clk);
        trig_in = ~pol[0];
        for (int i = 0; i <= arr + 8; i++) begin
            int j;
            @(negedge clk);
            j = i - 2;
            check((j == 0) ? "R1" : (retrig ? "R8" : "R2"), busy, (j >= 0 && j <= arr));
            check(retrig ? "R8" : pulse_tag(mode, fast, j, arr),
                  pulse_out, exp_pulse(mode, fast, cmp, arr, j));
            if (retrig && i == 2) trig_in = pol[0];
            if (retrig && i == 4) trig_in = ~pol[0];
        end
        trig_in = pol[0];
        repeat (3) @(negedge clk);
        check(retrig ? "R8" : "R10", busy, 1'b0);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", busy, 1'b0);
        check("R9", pulse_out, 1'b0);
        @(negedge clk);
        rst     = 1'b0;
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R10", pulse_out, 1'b0);

        for (int pol = 0; pol < 2; pol++)
            for (int mode = 0; mode < 4; mode++)
                for (int fast = 0; fast < 2; fast++)
                    for (int arr = 0; arr < 6; arr++)
                        for (int cmp = 0; cmp < 6; cmp++)
                            run_pulse(pol, mode, fast, cmp, arr, 1'b0);

        run_pulse(0, 2, 0, 2, 7, 1'b1);
        run_pulse(1, 1, 0, 3, 7, 1'b1);
        run_pulse(0, 2, 1, 0, 7, 1'b1);

        // Reset mid-run clears both outputs (R9).
        @(negedge clk);
        edge_falling = 1'b0; mode_sel = 2'b10; fast_start = 1'b1;
        reload_val = CNT_W'(9); trig_in = 1'b0;
        repeat (3) @(negedge clk);
        trig_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R5", pulse_out, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R9", busy, 1'b0);
        check("R9", pulse_out, 1'b0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule